// File: doc/BRIEF.md
# Power-Management Sleep Control Register

This block is a single 16-bit power-management control register on a simple I/O bus. The bus can access it as a halfword, or as either of its two bytes. It holds the interrupt-routing enable and the sleep-type field. Two of its bits can only be written, and they always read back as zero.

Software starts a sleep transition by writing the sleep-type field with the sleep-enable bit set. The block decodes that write. It then issues one-cycle requests to the platform: a reset request together with a suspend-flag strobe for the suspend-to-RAM type, or a shutdown request for the hibernate and soft-off types. The sleep-enable bit is never kept in the register.

Top module: `pm1_ctrl_reg`

## Requirements
- R1: After reset the stored value is 16'h0001: only bit 0 (interrupt-routing enable) is set, and `sci_en` is 1.
- R2: A byte write (`req_size`=0) to address BASE+5 loads `req_wdata[7:0]` into bits 15:8. A byte write to BASE+4 loads `req_wdata[7:0]` into bits 7:0. A halfword write (`req_size`=1) to BASE+4 loads all 16 bits. Any other address, and a halfword at BASE+5, is ignored.
- R3: Bit 2 (lock release) and bit 13 (sleep enable) always read as 0.
- R4: Bit 13 is never stored. A later read shows it as 0 after any write, including a write that had it set.
- R5: A byte write to the low byte never produces a request pulse, whatever its data.
- R6: When a halfword write or a high-byte write has bit 13 of the written value set, bits 12:10 of that value are decoded. For a high-byte write these are data bits 5 and 4:2. The value 5 pulses both `rst_req` and `s3_flag`. The value 6 or 7 pulses `shutdown_req`. Any other value pulses nothing.
- R7: A request pulse lasts exactly one cycle. It appears in the cycle that follows the write, and no cycle without a decoded write carries one.
- R8: A read at BASE+4 as a halfword returns the masked 16-bit value. A byte read at BASE+4 returns masked bits 7:0, and a byte read at BASE+5 returns masked bits 15:8, both in `rd_data[7:0]` with the upper lane 0. An unmapped read returns 0. Read data is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = byte, 1 = halfword |
| req_addr | input | ADDR_W | I/O address |
| req_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| rd_data | output | 16 | Combinational read data |
| rst_req | output | 1 | System reset request pulse |
| s3_flag | output | 1 | Suspend-indication strobe, alongside rst_req |
| shutdown_req | output | 1 | Shutdown request pulse |
| sci_en | output | 1 | Stored interrupt-routing enable bit |

## Verification
Read data follows the address within the same cycle, so the bench samples it 1 ns after it drives the read at a falling edge. The stored value and the request pulses are updated at the first rising edge after a write is driven. The bench therefore samples the pulses at the next falling edge, where each should be high for that one cycle. At the falling edge after that they must be low again, which checks the single-cycle rule.

// File: rtl/pm1_ctrl_reg.sv
module pm1_ctrl_reg #(
  parameter int ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h40,
  parameter int OFS           = 4,
  parameter logic [15:0] RESET_VAL = 16'h0001,
  parameter int SCI_BIT       = 0,
  parameter int GLR_BIT       = 2,
  parameter int SLPEN_BIT     = 13,
  parameter int TYP_LSB       = 10,
  parameter logic [2:0] TYP_SUSPEND = 3'd5,
  parameter logic [2:0] TYP_HIBER   = 3'd6,
  parameter logic [2:0] TYP_OFF     = 3'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic [15:0]       rd_data,
  output logic              rst_req,
  output logic              s3_flag,
  output logic              shutdown_req,
  output logic              sci_en
);
  localparam logic [ADDR_W-1:0] LO_ADDR = BASE + ADDR_W'(OFS);
  localparam logic [ADDR_W-1:0] HI_ADDR = BASE + ADDR_W'(OFS + 1);
  localparam logic [15:0] WO_MASK = (16'h1 << GLR_BIT) | (16'h1 << SLPEN_BIT);
  localparam logic [15:0] SLP_MASK = 16'h1 << SLPEN_BIT;

  logic [15:0] ctrl;
  logic [15:0] vis;
  logic        at_lo, at_hi;
  logic        wr_lo_b, wr_hi_b, wr_half;
  logic [15:0] dec_word;
  logic        dec_go;
  logic [2:0]  typ;

  assign at_lo   = req_addr == LO_ADDR;
  assign at_hi   = req_addr == HI_ADDR;
  assign wr_lo_b = req_valid && req_write && !req_size && at_lo;
  assign wr_hi_b = req_valid && req_write && !req_size && at_hi;
  assign wr_half = req_valid && req_write &&  req_size && at_lo;

  assign dec_word = wr_half ? req_wdata : {req_wdata[7:0], 8'h00};
  assign dec_go   = (wr_half || wr_hi_b) && dec_word[SLPEN_BIT];
  assign typ      = dec_word[TYP_LSB +: 3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl         <= RESET_VAL;
      rst_req      <= 1'b0;
      s3_flag      <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      if (wr_half)      ctrl <= req_wdata & ~SLP_MASK;
      else if (wr_hi_b) ctrl <= {req_wdata[7:0], ctrl[7:0]} & ~SLP_MASK;
      else if (wr_lo_b) ctrl <= {ctrl[15:8], req_wdata[7:0]};
      rst_req      <= dec_go && (typ == TYP_SUSPEND);
      s3_flag      <= dec_go && (typ == TYP_SUSPEND);
      shutdown_req <= dec_go && (typ == TYP_HIBER || typ == TYP_OFF);
    end
  end

  assign vis    = ctrl & ~WO_MASK;
  assign sci_en = ctrl[SCI_BIT];

  always_comb begin
    rd_data = 16'h0000;
    if (req_valid && !req_write) begin
      if (req_size && at_lo)       rd_data = vis;
      else if (!req_size && at_lo) rd_data = {8'h00, vis[7:0]};
      else if (!req_size && at_hi) rd_data = {8'h00, vis[15:8]};
    end
  end
endmodule

module pm1_ctrl_reg_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h40,
  parameter int OFS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic [15:0]       req_wdata,
  input logic [15:0]       rd_data,
  input logic              rst_req,
  input logic              s3_flag,
  input logic              shutdown_req
);
  localparam logic [ADDR_W-1:0] LO = BASE + ADDR_W'(OFS);
  localparam logic [ADDR_W-1:0] HI = BASE + ADDR_W'(OFS + 1);
  logic dec_wr;
  assign dec_wr = req_valid && req_write &&
                  ((req_size && req_addr == LO) || (!req_size && req_addr == HI));

  a_r3_wo_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size && req_addr == LO) |-> (rd_data[13] == 1'b0 && rd_data[2] == 1'b0));
  a_r5_low_byte_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_size && req_addr == LO) |=> (!rst_req && !shutdown_req && !s3_flag));
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_wr |=> (!rst_req && !shutdown_req && !s3_flag));
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && shutdown_req));
  a_r6_s3_pair: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req == s3_flag);
  a_r8_upper_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_size) |-> rd_data[15:8] == 8'h00);
endmodule

bind pm1_ctrl_reg pm1_ctrl_reg_chk #(.ADDR_W(ADDR_W), .BASE(BASE), .OFS(OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
  .rd_data(rd_data), .rst_req(rst_req), .s3_flag(s3_flag), .shutdown_req(shutdown_req)
);

// File: tb/test_pm1_ctrl_reg.sv
module test_pm1_ctrl_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0;
  logic [7:0] req_addr = 8'h00;
  logic [15:0] req_wdata = 16'h0000;
  logic [15:0] rd_data;
  logic rst_req, s3_flag, shutdown_req, sci_en;
  int checks = 0, fails = 0;
  logic [15:0] model = 16'h0001;
  logic exp_rst, exp_sd;

  always #2 clk = ~clk;

  pm1_ctrl_reg i_pm1_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rst_req(rst_req), .s3_flag(s3_flag),
    .shutdown_req(shutdown_req), .sci_en(sci_en));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic sz, output logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = sz; req_addr = a;
    #1 d = rd_data;
    req_valid = 1'b0;
  endtask

  task automatic check_reads(input string tag);
    logic [15:0] d, vis;
    vis = model & 16'hDFFB;
    rd(8'h44, 1'b1, d); chk({tag, " R8 R3 half read"}, d, vis);
    rd(8'h44, 1'b0, d); chk({tag, " R8 low byte read"}, d, {8'h00, vis[7:0]});
    rd(8'h45, 1'b0, d); chk({tag, " R8 high byte read"}, d, {8'h00, vis[15:8]});
    chk({tag, " R1 sci_en"}, {15'h0, sci_en}, {15'h0, model[0]});
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic sz, input logic [15:0] v);
    logic [15:0] dw;
    logic go;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = sz; req_addr = a; req_wdata = v;
    dw = 16'h0; go = 1'b0;
    if (sz && a == 8'h44) begin model = v & 16'hDFFF; dw = v; go = 1'b1; end
    else if (!sz && a == 8'h45) begin model = {v[7:0], model[7:0]} & 16'hDFFF; dw = {v[7:0], 8'h00}; go = 1'b1; end
    else if (!sz && a == 8'h44) model = {model[15:8], v[7:0]};
    exp_rst = go && dw[13] && dw[12:10] == 3'd5;
    exp_sd  = go && dw[13] && (dw[12:10] == 3'd6 || dw[12:10] == 3'd7);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk({tag, " R6 rst_req"}, {15'h0, rst_req}, {15'h0, exp_rst});
    chk({tag, " R6 s3_flag"}, {15'h0, s3_flag}, {15'h0, exp_rst});
    chk({tag, " R6 R5 shutdown_req"}, {15'h0, shutdown_req}, {15'h0, exp_sd});
    @(negedge clk);
    chk({tag, " R7 pulse ends"}, {13'h0, rst_req, s3_flag, shutdown_req}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_reads("R1 reset");
    for (int h = 0; h < 256; h++) begin
      wr("R2 R4 half", 8'h44, 1'b1, {h[7:0], 8'hA5 ^ h[7:0]});
      check_reads("R2 half");
    end
    for (int h = 0; h < 256; h++) begin
      wr("R2 R4 high byte", 8'h45, 1'b0, {8'h5A, h[7:0]});
      check_reads("R2 high");
    end
    wr("R2 setup", 8'h44, 1'b1, 16'h1C00);
    for (int l = 0; l < 256; l++) begin
      wr("R5 low byte", 8'h44, 1'b0, {8'hFF, l[7:0]});
      check_reads("R5 low");
    end
    wr("R2 unmapped", 8'h46, 1'b1, 16'hFFFF);
    check_reads("R2 unmapped");
    wr("R2 half at hi", 8'h45, 1'b1, 16'h3400);
    check_reads("R2 half at hi");
    begin
      logic [15:0] d;
      rd(8'h47, 1'b1, d); chk("R8 unmapped read", d, 16'h0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule